// File: doc/BRIEF.md
# Linear flash read-ahead engine

This block streams a contiguous run of 32-bit words out of a serial flash into a small word FIFO. Software reads those words back one at a time through a data register. To start a session, software writes a start byte address and a length in words, then sets the start bit in the control register. The engine then makes a single read request toward the flash side. That request carries the programmed opcode, the dummy-bit count, a lane width for each phase and the address width. The engine then accepts the returned byte stream and packs every four bytes little-endian into a word for the FIFO.

The serial pin timing is not part of this block. The flash side is a request pulse followed by a valid/ready byte stream. The sequencer has three named states. `SEQ_IDLE` moves to `SEQ_ISSUE` when a start is accepted. `SEQ_ISSUE` always moves to `SEQ_STREAM` after one cycle. `SEQ_STREAM` returns to `SEQ_IDLE` on the clock edge that writes the final word. While the FIFO is full the byte stream is held off, so nothing is lost. Software treats "FIFO empty and not busy" as the end of a read.

In 4-byte address mode, the top address byte comes from its own register and the start register supplies only the low 24 bits. The low 24 bits wrap within the 16 MB window and never carry into the top byte.

Top module: `flash_stream_reader`

## Requirements
- R1: After reset, status (offset 0x14) reads 0x2: bit 0 is busy and reads 0, bit 1 is FIFO-empty and reads 1. The fullness (0x0C), words-done (0x1C) and current-address (0x20) registers read 0, and a data read (0x18) returns 0.
- R2: Writing 1 to bit 0 of control (0x08) while idle with a nonzero word count (0x04) raises busy and pulses `fl_req` for exactly one cycle. During that pulse, `fl_opcode`, `fl_dummy_bits`, `fl_lanes` ({data, addr, cmd}, each log2 of the line count) and `fl_addr4` reflect the read-config register.
- R3: Bytes are packed little-endian: the first byte of each group of four lands in bits 7:0 and the fourth in bits 31:24.
- R4: A session ends after exactly the programmed number of words. Busy falls on the edge that writes the last word, and words-done then equals the count.
- R5: The FIFO holds 16 words. While it is full, `fl_byte_ready` is low, fullness reads 16, busy stays high, and no word is lost or reordered.
- R6: A data read pops one word. A data read while the FIFO is empty returns 0 and leaves fullness at 0.
- R7: A start written while busy is ignored. No second request is made and the running session's length is unchanged.
- R8: A start with a word count of 0 is ignored. Busy stays low and no request is made.
- R9: With `addr4` (read-config bit 24) set, `fl_addr` is {upper-byte register 0x28 bits 7:0, start address bits 23:0}. With `addr4` clear, its top byte is 0. Start-address bits 31:24 are never used.
- R10: The current address advances by one per accepted byte. Its low 24 bits wrap from 0xFFFFFF to 0 and its top byte does not change.
- R11: Fullness reports the number of words held, and the status empty bit is set exactly when that number is 0.
- R12: Read-config (0x24: opcode 7:0, dummy bits 15:8, cmd lanes 17:16, addr lanes 19:18, data lanes 21:20, addr4 bit 24), upper byte (0x28) and watermark (0x10, 5 bits) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the data offset) |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| fl_req | output | 1 | One-cycle read request to the flash side |
| fl_sel | output | 1 | High for the whole session |
| fl_addr | output | 32 | Request byte address |
| fl_addr4 | output | 1 | 4-byte address phase |
| fl_opcode | output | 8 | Read opcode |
| fl_dummy_bits | output | 8 | Dummy bit count |
| fl_lanes | output | 6 | {data, addr, cmd} lane widths, log2 each |
| fl_byte_valid | input | 1 | Flash byte available |
| fl_byte | input | 8 | Flash byte |
| fl_byte_ready | output | 1 | Engine accepts the byte this cycle |

## Verification
The embedded properties check, on every cycle, the following rules. The request is a single-cycle pulse that is always followed by streaming. No push reaches a full FIFO. An empty pop leaves the level at zero. The remaining count changes only when a word is written, so a start during a session cannot reload it. The session closes on the edge of its final word. The top address byte holds between accepted starts. Only the bench scenarios show the data-related behaviour. That covers the little-endian byte order and the exact words delivered under backpressure. It also covers the address presented to the flash in each address mode, the wrap of the low 24 bits, and the register readback values.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ISSUE,
        SEQ_STREAM
    } seq_state_t;

    localparam logic [5:0] OFF_START = 6'h00;
    localparam logic [5:0] OFF_COUNT = 6'h04;
    localparam logic [5:0] OFF_CTRL  = 6'h08;
    localparam logic [5:0] OFF_LEVEL = 6'h0C;
    localparam logic [5:0] OFF_WMARK = 6'h10;
    localparam logic [5:0] OFF_STAT  = 6'h14;
    localparam logic [5:0] OFF_DATA  = 6'h18;
    localparam logic [5:0] OFF_DONE  = 6'h1C;
    localparam logic [5:0] OFF_CADDR = 6'h20;
    localparam logic [5:0] OFF_RCFG  = 6'h24;
    localparam logic [5:0] OFF_UPPER = 6'h28;

    typedef struct packed {
        logic       addr4;
        logic [1:0] data_lanes;
        logic [1:0] addr_lanes;
        logic [1:0] cmd_lanes;
        logic [7:0] dummy_bits;
        logic [7:0] opcode;
    } rd_cfg_t;

endpackage

// File: rtl/fsr_word_fifo.sv
`timescale 1ns/1ps
module fsr_word_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_pop = pop && (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            unique case ({push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];
    assign level = cnt;
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (level == '0));

endmodule

// File: rtl/fsr_byte_packer.sv
`timescale 1ns/1ps
module fsr_byte_packer #(
    parameter int BYTES = 4,
    localparam int W  = 8 * BYTES,
    localparam int IW = $clog2(BYTES)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         fire,
    input  logic [7:0]   din,
    output logic         word_valid,
    output logic [W-1:0] word
);

    logic [W-9:0]  acc;
    logic [IW-1:0] idx;
    logic          last;

    assign last       = (idx == IW'(BYTES - 1));
    assign word_valid = fire && last;
    assign word       = {din, acc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (fire) begin
            if (!last) acc[int'(idx) * 8 +: 8] <= din;
            idx <= last ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/fsr_sequencer.sv
`timescale 1ns/1ps
module fsr_sequencer
    import fsr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic [23:0]      base_low,
    input  logic [7:0]       upper,
    input  logic             addr4,
    input  logic             byte_fire,
    input  logic             word_push,
    output logic             accept,
    output logic             busy,
    output logic             fl_req,
    output logic             stream_en,
    output logic [31:0]      cur_addr,
    output logic [CNT_W-1:0] done_cnt
);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] left;
    logic [23:0]      cur_low;
    logic [7:0]       cur_hi;
    logic             final_word;

    assign accept     = (state == SEQ_IDLE) && start && (len != '0);
    assign final_word = word_push && (left == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:   if (accept) state_nx = SEQ_ISSUE;
            SEQ_ISSUE:  state_nx = SEQ_STREAM;
            SEQ_STREAM: if (final_word) state_nx = SEQ_IDLE;
            default:    state_nx = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        fl_req    = 1'b0;
        stream_en = 1'b0;
        unique case (state)
            SEQ_IDLE:   ;
            SEQ_ISSUE:  begin busy = 1'b1; fl_req = 1'b1; end
            SEQ_STREAM: begin busy = 1'b1; stream_en = 1'b1; end
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left     <= '0;
            cur_low  <= '0;
            cur_hi   <= '0;
            done_cnt <= '0;
        end else if (accept) begin
            left     <= len;
            cur_low  <= base_low;
            cur_hi   <= addr4 ? upper : 8'h00;
            done_cnt <= '0;
        end else begin
            if (byte_fire) cur_low <= cur_low + 1'b1;
            if (word_push) begin
                left     <= left - 1'b1;
                done_cnt <= done_cnt + 1'b1;
            end
        end
    end

    assign cur_addr = {cur_hi, cur_low};

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |=> (!fl_req && stream_en));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !word_push) |=> $stable(left));

    // R4
    session_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        final_word |=> !busy);

    // R4
    no_excess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_en |-> (left != '0));

    // R10
    window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(cur_addr[31:24]));

endmodule

// File: rtl/flash_stream_reader.sv
`timescale 1ns/1ps
module flash_stream_reader
    import fsr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        fl_req,
    output logic        fl_sel,
    output logic [31:0] fl_addr,
    output logic        fl_addr4,
    output logic [7:0]  fl_opcode,
    output logic [7:0]  fl_dummy_bits,
    output logic [5:0]  fl_lanes,
    input  logic        fl_byte_valid,
    input  logic [7:0]  fl_byte,
    output logic        fl_byte_ready
);

    logic [31:0]      start_r;
    logic [CNT_W-1:0] count_r;
    logic [LVL_W-1:0] wmark_r;
    rd_cfg_t          cfg_r;
    logic [7:0]       upper_r;

    logic             start_wr, accept, busy, stream_en, byte_fire;
    logic             word_push, pop;
    logic [31:0]      word, fifo_rdata, cur_addr;
    logic [CNT_W-1:0] done_cnt;
    logic [LVL_W-1:0] level;
    logic             fifo_full, fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_r <= '0;
            count_r <= '0;
            wmark_r <= '0;
            cfg_r   <= '0;
            upper_r <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFF_START: start_r <= bus_wdata;
                OFF_COUNT: count_r <= bus_wdata[CNT_W-1:0];
                OFF_WMARK: wmark_r <= bus_wdata[LVL_W-1:0];
                OFF_RCFG:  cfg_r   <= '{addr4:      bus_wdata[24],
                                        data_lanes: bus_wdata[21:20],
                                        addr_lanes: bus_wdata[19:18],
                                        cmd_lanes:  bus_wdata[17:16],
                                        dummy_bits: bus_wdata[15:8],
                                        opcode:     bus_wdata[7:0]};
                OFF_UPPER: upper_r <= bus_wdata[7:0];
                default:   ;
            endcase
        end
    end

    assign start_wr  = bus_wr && (bus_addr == OFF_CTRL) && bus_wdata[0];
    assign pop       = bus_rd && (bus_addr == OFF_DATA);
    assign byte_fire = fl_byte_valid && fl_byte_ready;
    assign fl_byte_ready = stream_en && !fifo_full;

    fsr_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_wr),
        .len       (count_r),
        .base_low  (start_r[23:0]),
        .upper     (upper_r),
        .addr4     (cfg_r.addr4),
        .byte_fire (byte_fire),
        .word_push (word_push),
        .accept    (accept),
        .busy      (busy),
        .fl_req    (fl_req),
        .stream_en (stream_en),
        .cur_addr  (cur_addr),
        .done_cnt  (done_cnt)
    );

    fsr_byte_packer #(.BYTES(4)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .fire       (byte_fire),
        .din        (fl_byte),
        .word_valid (word_push),
        .word       (word)
    );

    fsr_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (word_push),
        .wdata (word),
        .pop   (pop),
        .rdata (fifo_rdata),
        .level (level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign fl_sel        = busy;
    assign fl_addr       = cur_addr;
    assign fl_addr4      = cfg_r.addr4;
    assign fl_opcode     = cfg_r.opcode;
    assign fl_dummy_bits = cfg_r.dummy_bits;
    assign fl_lanes      = {cfg_r.data_lanes, cfg_r.addr_lanes, cfg_r.cmd_lanes};

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_START: bus_rdata = start_r;
            OFF_COUNT: bus_rdata = 32'(count_r);
            OFF_LEVEL: bus_rdata = 32'(level);
            OFF_WMARK: bus_rdata = 32'(wmark_r);
            OFF_STAT:  bus_rdata = {30'b0, fifo_empty, busy};
            OFF_DATA:  bus_rdata = fifo_empty ? 32'h0 : fifo_rdata;
            OFF_DONE:  bus_rdata = 32'(done_cnt);
            OFF_CADDR: bus_rdata = cur_addr;
            OFF_RCFG:  bus_rdata = {7'b0, cfg_r.addr4, 2'b0, cfg_r.data_lanes,
                                    cfg_r.addr_lanes, cfg_r.cmd_lanes,
                                    cfg_r.dummy_bits, cfg_r.opcode};
            OFF_UPPER: bus_rdata = {24'b0, upper_r};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/test_flash_stream_reader.sv
`timescale 1ns/1ps
module test_flash_stream_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fl_req, fl_sel, fl_addr4, fl_byte_ready, fl_byte_valid;
    logic [31:0] fl_addr;
    logic [7:0]  fl_opcode, fl_dummy_bits, fl_byte;
    logic [5:0]  fl_lanes;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    flash_stream_reader i_flash_stream_reader (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fl_req(fl_req), .fl_sel(fl_sel), .fl_addr(fl_addr), .fl_addr4(fl_addr4),
        .fl_opcode(fl_opcode), .fl_dummy_bits(fl_dummy_bits), .fl_lanes(fl_lanes),
        .fl_byte_valid(fl_byte_valid), .fl_byte(fl_byte), .fl_byte_ready(fl_byte_ready)
    );

    function automatic logic [7:0] fbyte(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ (a[31:24] + 8'h17);
    endfunction

    // flash-side byte source
    logic [31:0] m_addr = '0;
    logic        m_on = 1'b0;
    logic        gap_en = 1'b0;
    logic        phase = 1'b0;
    int          req_cnt = 0;
    logic [31:0] cap_addr = '0;
    logic [7:0]  cap_op = '0, cap_dummy = '0;
    logic [5:0]  cap_lanes = '0;
    logic        cap_a4 = 1'b0;

    assign fl_byte_valid = m_on && (!gap_en || phase);
    assign fl_byte       = fbyte(m_addr);

    always @(posedge clk) begin
        phase <= ~phase;
        if (fl_req) begin
            m_addr    <= fl_addr;
            m_on      <= 1'b1;
            req_cnt   <= req_cnt + 1;
            cap_addr  <= fl_addr;
            cap_op    <= fl_opcode;
            cap_dummy <= fl_dummy_bits;
            cap_lanes <= fl_lanes;
            cap_a4    <= fl_addr4;
        end else if (!fl_sel) begin
            m_on <= 1'b0;
        end else if (fl_byte_valid && fl_byte_ready) begin
            m_addr <= {m_addr[31:24], m_addr[23:0] + 24'd1};
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // scoreboard
    logic [31:0] exp_q[$];

    task automatic expect_words(input logic [31:0] base, input int n);
        for (int w = 0; w < n; w++) begin
            logic [31:0] wd;
            for (int b = 0; b < 4; b++) begin
                logic [31:0] a;
                a = {base[31:24], base[23:0] + 24'(4 * w + b)};
                wd[8*b +: 8] = fbyte(a);
            end
            exp_q.push_back(wd);
        end
    endtask

    task automatic drain(input int n, input string req);
        logic [31:0] s, d;
        int got = 0;
        for (int t = 0; t < 4000 && got < n; t++) begin
            rd(6'h14, s);
            if (!s[1]) begin
                rd(6'h18, d);
                chk(req, d, exp_q.pop_front());
                got++;
            end
        end
        chk({req, " word count"}, 32'(got), 32'(n));
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int t = 0; t < 2000; t++) begin
            rd(6'h14, s);
            if (!s[0]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h14, v); chk("R1 status", v, 32'h2);
        rd(6'h0C, v); chk("R1 level", v, 0);
        rd(6'h1C, v); chk("R1 done", v, 0);
        rd(6'h20, v); chk("R1 caddr", v, 0);
        rd(6'h18, v); chk("R1 data", v, 0);

        // R12 readback
        wr(6'h24, 32'h0020_086B); rd(6'h24, v); chk("R12 rcfg", v, 32'h0020_086B);
        wr(6'h28, 32'h0000_005C); rd(6'h28, v); chk("R12 upper", v, 32'h5C);
        wr(6'h10, 32'h0000_0005); rd(6'h10, v); chk("R12 wmark", v, 32'h5);

        // Session A: 3-byte mode, R2 R3 R4 R9 R11
        wr(6'h00, 32'hAB00_1230);
        wr(6'h04, 32'd3);
        expect_words(32'h0000_1230, 3);
        wr(6'h08, 32'h1);
        wait_idle();
        chk("R2 req count", 32'(req_cnt), 1);
        chk("R2 opcode", 32'(cap_op), 32'h6B);
        chk("R2 dummy", 32'(cap_dummy), 32'h08);
        chk("R2 lanes", 32'(cap_lanes), 32'b10_00_00);
        chk("R9 3-byte addr4", 32'(cap_a4), 0);
        chk("R9 3-byte address", cap_addr, 32'h0000_1230);
        rd(6'h1C, v); chk("R4 done count", v, 3);
        rd(6'h0C, v); chk("R11 level", v, 3);
        rd(6'h14, v); chk("R11 status not empty", v, 32'h0);
        rd(6'h20, v); chk("R10 caddr", v, 32'h0000_123C);
        drain(3, "R3 packing");
        rd(6'h14, v); chk("R11 status empty", v, 32'h2);

        // Session B: 4-byte mode with wrap, R9 R10
        wr(6'h24, 32'h0120_086B);
        wr(6'h28, 32'h12);
        wr(6'h00, 32'h00FF_FFFE);
        wr(6'h04, 32'd2);
        expect_words(32'h12FF_FFFE, 2);
        wr(6'h08, 32'h1);
        wait_idle();
        chk("R9 4-byte address", cap_addr, 32'h12FF_FFFE);
        chk("R9 addr4", 32'(cap_a4), 1);
        rd(6'h20, v); chk("R10 wrap caddr", v, 32'h1200_0006);
        drain(2, "R10 wrap data");

        // Session C: backpressure R5, start while busy R7
        wr(6'h24, 32'h0020_086B);
        wr(6'h00, 32'h0040_0000);
        wr(6'h04, 32'd20);
        expect_words(32'h0040_0000, 20);
        gap_en = 1'b1;
        wr(6'h08, 32'h1);
        repeat (300) @(negedge clk);
        chk("R5 ready low when full", 32'(fl_byte_ready), 0);
        rd(6'h0C, v); chk("R5 level full", v, 16);
        rd(6'h14, v); chk("R5 busy while full", v, 32'h1);
        rd(6'h1C, v); chk("R5 done at stall", v, 16);
        chk("R9 3-byte upper zero", cap_addr, 32'h0040_0000);
        wr(6'h04, 32'd2);
        wr(6'h08, 32'h1);
        chk("R7 no second request", 32'(req_cnt), 3);
        drain(20, "R5 stream");
        wait_idle();
        rd(6'h1C, v); chk("R7 length kept", v, 20);
        chk("R7 request count", 32'(req_cnt), 3);
        gap_en = 1'b0;

        // R8 zero-length start
        wr(6'h04, 32'd0);
        wr(6'h08, 32'h1);
        repeat (5) @(negedge clk);
        rd(6'h14, v); chk("R8 stays idle", v, 32'h2);
        chk("R8 no request", 32'(req_cnt), 3);

        // R6 empty read
        rd(6'h18, v); chk("R6 empty read", v, 0);
        rd(6'h0C, v); chk("R6 level after empty read", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule